// File: doc/BRIEF.md
# Narrow-Bus Word Packer and Unpacker

This block connects a 32-bit internal data path to an external memory data bus that runs either 8 or 16 bits wide. In the receive direction it collects narrow beats arriving from the bus and assembles them into full 32-bit words. In the transmit direction it takes a 32-bit word and emits it as a series of narrow beats: two in 16-bit mode, four in 8-bit mode. Each of the four streams uses a valid/ready handshake. Address generation and memory strobes belong to other logic.

Three static configuration inputs shape the behaviour. The first selects the bus width. The second chooses whether the first narrow beat of a group maps to the lowest or the highest lane of the word. The third turns packing off. With packing off, every received beat becomes a zero-extended word of its own, and every transmit word sends only its low part as one beat. A synchronous clear throws away any partly assembled receive word and any transmit word that is still being emitted.

Top module: `lane_packer`

## Requirements
- R1: With packing on, 16-bit mode and `cfg_msb_first`=0, the first received beat lands in bits [15:0] of the word and the second lands in bits [31:16].
- R2: With packing on, 8-bit mode and `cfg_msb_first`=0, received beat k (k=0..3) lands in bits [8k+7:8k], and only `nin_data[7:0]` is used.
- R3: With packing on and `cfg_msb_first`=1, lanes fill from the top down: in 16-bit mode the first beat goes to [31:16]; in 8-bit mode beat k goes to byte lane 3-k.
- R4: `wout_valid` rises only in the cycle after the final beat of a group is accepted (beat 2 in 16-bit mode, beat 4 in 8-bit mode). While `wout_ready` is low, both the word and its valid hold steady and `nin_ready` is low.
- R5: With packing off, each received beat comes out alone as a 32-bit word, zero-extended from 16 bits in 16-bit mode or from `nin_data[7:0]` in 8-bit mode.
- R6: With packing on, an accepted transmit word is emitted as 2 beats (16-bit mode) or 4 beats (8-bit mode), using the same lane order as receive. The first beat is valid in the cycle after the word is accepted.
- R7: With packing off, a transmit word is emitted as one beat carrying its low 16 bits (16-bit mode) or low 8 bits (8-bit mode). `cfg_msb_first` has no effect in this mode, in either direction.
- R8: `win_ready` stays low from the cycle after a transmit word is accepted until its final beat has been taken. A narrow beat holds its value while `nout_ready` is low.
- R9: In 8-bit mode, `nout_data[15:8]` is always zero.
- R10: `clr` high for one cycle drops any partial receive word, any unconsumed packed word and any transmit word still pending. On the next cycle both valid outputs are low and `win_ready` is high, and the next received beat starts a new word.
- R11: After reset, `wout_valid` and `nout_valid` are low, while `nin_ready` and `win_ready` are high.
- R12: A configuration change made while the block is idle applies from the next word onward, with nothing left over from the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of partial and pending words |
| cfg_wide | input | 1 | Bus width: 1 = 16-bit, 0 = 8-bit |
| cfg_nopack | input | 1 | 1 = packing off |
| cfg_msb_first | input | 1 | 1 = first beat in the most significant lane |
| nin_valid | input | 1 | Narrow receive beat valid |
| nin_ready | output | 1 | Narrow receive beat accepted |
| nin_data | input | 16 | Narrow receive beat |
| wout_valid | output | 1 | Packed word valid |
| wout_ready | input | 1 | Packed word taken |
| wout_data | output | 32 | Packed word |
| win_valid | input | 1 | Transmit word valid |
| win_ready | output | 1 | Transmit word accepted |
| win_data | input | 32 | Transmit word |
| nout_valid | output | 1 | Narrow transmit beat valid |
| nout_ready | input | 1 | Narrow transmit beat taken |
| nout_data | output | 16 | Narrow transmit beat |

## Verification
The assertions assume the three configuration inputs stay constant whenever a receive group is partly filled, a packed word is waiting, or a transmit word is being emitted. They also assume that clear and reset are the only events that drop state in the middle of a word. The stimulus changes configuration only once both reference queues have drained and a few idle cycles have passed. It always sends complete groups in each mode, except in the clear test, where it raises `clr` on purpose over a partial group with all readies held low.

// File: rtl/lane_packer_pkg.sv
package lane_packer_pkg;

    localparam int WORD_W    = 32;
    localparam int NAR_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int MAX_BEATS = WORD_W / BYTE_W;
    localparam int CNT_W     = $clog2(MAX_BEATS);

    typedef enum logic {
        BUS_X8  = 1'b0,
        BUS_X16 = 1'b1
    } bus_width_e;

    typedef struct packed {
        bus_width_e width;
        logic       no_pack;
        logic       msb_first;
    } pack_cfg_t;

    // index of the final beat of a group
    function automatic logic [CNT_W-1:0] last_beat(input pack_cfg_t c);
        if (c.no_pack)
            return '0;
        else if (c.width == BUS_X16)
            return CNT_W'(WORD_W / NAR_W - 1);
        else
            return CNT_W'(WORD_W / BYTE_W - 1);
    endfunction

    // lane that beat number 'beat' occupies
    function automatic logic [CNT_W-1:0] lane_of(input pack_cfg_t c,
                                                 input logic [CNT_W-1:0] beat);
        if (c.msb_first && !c.no_pack)
            return last_beat(c) - beat;
        else
            return beat;
    endfunction

    // narrow beat moved into its lane, zero elsewhere
    function automatic logic [WORD_W-1:0] place(input pack_cfg_t c,
                                                input logic [CNT_W-1:0] lane,
                                                input logic [NAR_W-1:0] d);
        logic [WORD_W-1:0] w;
        w = '0;
        if (c.width == BUS_X16)
            w[{lane[0], 4'b0000} +: NAR_W] = d;
        else
            w[{lane, 3'b000} +: BYTE_W] = d[BYTE_W-1:0];
        return w;
    endfunction

    // narrow beat taken from a lane, upper byte cleared in 8-bit mode
    function automatic logic [NAR_W-1:0] extract(input pack_cfg_t c,
                                                 input logic [WORD_W-1:0] w,
                                                 input logic [CNT_W-1:0] lane);
        if (c.width == BUS_X16)
            return w[{lane[0], 4'b0000} +: NAR_W];
        else
            return {{(NAR_W-BYTE_W){1'b0}}, w[{lane, 3'b000} +: BYTE_W]};
    endfunction

endpackage

// File: rtl/beat_counter.sv
module beat_counter
    import lane_packer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);

    assign at_last = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (adv)
            cnt <= at_last ? '0 : cnt + 1'b1;
    end

    // the count never passes the final beat of the group
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);

endmodule

// File: rtl/rx_assembler.sv
module rx_assembler
    import lane_packer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  pack_cfg_t         cfg,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [NAR_W-1:0]  in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);

    logic              out_v;
    logic [WORD_W-1:0] acc;
    logic [CNT_W-1:0]  cnt;
    logic              at_last;
    logic              take;
    logic [WORD_W-1:0] placed;

    assign in_ready  = !(out_v && !out_ready);
    assign take      = in_valid && in_ready;
    assign placed    = place(cfg, lane_of(cfg, cnt), in_data);
    assign out_valid = out_v;
    assign out_data  = acc;

    beat_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .adv     (take),
        .last    (last_beat(cfg)),
        .cnt     (cnt),
        .at_last (at_last)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            out_v <= 1'b0;
            acc   <= '0;
        end else begin
            if (out_v && out_ready)
                out_v <= 1'b0;
            if (take) begin
                acc <= (cnt == '0) ? placed : (acc | placed);
                if (at_last)
                    out_v <= 1'b1;
            end
        end
    end

    assert_hold_word_R4: assert property (@(posedge clk) disable iff (rst || clr)
        (out_v && !out_ready) |=> (out_v && $stable(out_data)));

    assert_block_input_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    assert_zero_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cfg.no_pack) |->
            (out_data[WORD_W-1:NAR_W] == '0) &&
            (cfg.width == BUS_X16 || out_data[NAR_W-1:BYTE_W] == '0));

    assert_cfg_steady_R12: assert property (@(posedge clk) disable iff (rst || clr)
        (out_v || cnt != '0) |=> $stable(cfg));

endmodule

// File: rtl/tx_splitter.sv
module tx_splitter
    import lane_packer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  pack_cfg_t         cfg,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [NAR_W-1:0]  out_data
);

    logic              busy;
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  cnt;
    logic              at_last;
    logic              adv;

    assign in_ready  = !busy;
    assign out_valid = busy;
    assign adv       = busy && out_ready;
    assign out_data  = extract(cfg, word_q, lane_of(cfg, cnt));

    beat_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .adv     (adv),
        .last    (last_beat(cfg)),
        .cnt     (cnt),
        .at_last (at_last)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            busy   <= 1'b0;
            word_q <= '0;
        end else if (in_valid && in_ready) begin
            busy   <= 1'b1;
            word_q <= in_data;
        end else if (adv && at_last) begin
            busy   <= 1'b0;
        end
    end

    assert_first_beat_R6: assert property (@(posedge clk) disable iff (rst || clr)
        (in_valid && in_ready) |=> out_valid);

    assert_beat_hold_R8: assert property (@(posedge clk) disable iff (rst || clr)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cfg.width == BUS_X8) |-> (out_data[NAR_W-1:BYTE_W] == '0));

    assert_cfg_steady_R12: assert property (@(posedge clk) disable iff (rst || clr)
        busy |=> $stable(cfg));

endmodule

// File: rtl/lane_packer.sv
module lane_packer
    import lane_packer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cfg_wide,
    input  logic              cfg_nopack,
    input  logic              cfg_msb_first,
    input  logic              nin_valid,
    output logic              nin_ready,
    input  logic [NAR_W-1:0]  nin_data,
    output logic              wout_valid,
    input  logic              wout_ready,
    output logic [WORD_W-1:0] wout_data,
    input  logic              win_valid,
    output logic              win_ready,
    input  logic [WORD_W-1:0] win_data,
    output logic              nout_valid,
    input  logic              nout_ready,
    output logic [NAR_W-1:0]  nout_data
);

    pack_cfg_t cfg;

    assign cfg.width     = bus_width_e'(cfg_wide);
    assign cfg.no_pack   = cfg_nopack;
    assign cfg.msb_first = cfg_msb_first;

    rx_assembler u_rx (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .cfg       (cfg),
        .in_valid  (nin_valid),
        .in_ready  (nin_ready),
        .in_data   (nin_data),
        .out_valid (wout_valid),
        .out_ready (wout_ready),
        .out_data  (wout_data)
    );

    tx_splitter u_tx (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .cfg       (cfg),
        .in_valid  (win_valid),
        .in_ready  (win_ready),
        .in_data   (win_data),
        .out_valid (nout_valid),
        .out_ready (nout_ready),
        .out_data  (nout_data)
    );

    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!wout_valid && !nout_valid && win_ready));

endmodule

// File: tb/lane_packer_tb_top.sv
`timescale 1ns/1ps
module lane_packer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        cfg_wide = 1'b1, cfg_nopack = 1'b0, cfg_msb = 1'b0;
    logic        nin_valid = 1'b0, nin_ready;
    logic [15:0] nin_data = '0;
    logic        wout_valid, wout_ready = 1'b0;
    logic [31:0] wout_data;
    logic        win_valid = 1'b0, win_ready;
    logic [31:0] win_data = '0;
    logic        nout_valid, nout_ready = 1'b0;
    logic [15:0] nout_data;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    bit    rdy_en = 1'b0;
    bit    rdy_ok = 1'b0;
    string rx_note = "";
    logic [31:0] rxq[$];
    logic [15:0] txq[$];
    int          m_cnt = 0;
    logic [31:0] m_acc = '0;

    always #2 clk = ~clk;

    lane_packer dut_i (
        .clk (clk), .rst (rst), .clr (clr),
        .cfg_wide (cfg_wide), .cfg_nopack (cfg_nopack), .cfg_msb_first (cfg_msb),
        .nin_valid (nin_valid), .nin_ready (nin_ready), .nin_data (nin_data),
        .wout_valid (wout_valid), .wout_ready (wout_ready), .wout_data (wout_data),
        .win_valid (win_valid), .win_ready (win_ready), .win_data (win_data),
        .nout_valid (nout_valid), .nout_ready (nout_ready), .nout_data (nout_data)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbeats();
        return cfg_nopack ? 1 : (cfg_wide ? 2 : 4);
    endfunction

    function automatic int lwidth();
        return cfg_wide ? 16 : 8;
    endfunction

    function automatic string rx_tag();
        if (cfg_nopack) return cfg_msb ? "R7" : "R5";
        if (cfg_msb)    return "R3";
        return cfg_wide ? "R1" : "R2";
    endfunction

    // reference model, evaluated once per cycle away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            if (clr) begin
                rxq.delete();
                txq.delete();
                m_cnt = 0;
            end else begin
                logic [31:0] e;
                chk(!(wout_valid && rxq.size() == 0), "R4", {31'b0, wout_valid}, 32'h0);
                if (wout_valid && wout_ready && rxq.size() != 0) begin
                    e = rxq.pop_front();
                    chk(wout_data == e, (rx_note != "") ? rx_note : rx_tag(), wout_data, e);
                    rx_note = "";
                end
                if (nin_valid && nin_ready) begin
                    logic [31:0] d;
                    d = cfg_wide ? {16'h0, nin_data} : {24'h0, nin_data[7:0]};
                    if (cfg_nopack) begin
                        rxq.push_back(d);
                    end else begin
                        int lane;
                        lane = cfg_msb ? (nbeats() - 1 - m_cnt) : m_cnt;
                        if (m_cnt == 0) m_acc = '0;
                        m_acc = m_acc | (d << (lane * lwidth()));
                        m_cnt++;
                        if (m_cnt == nbeats()) begin
                            rxq.push_back(m_acc);
                            m_cnt = 0;
                        end
                    end
                end
                chk(!(txq.size() != 0 && win_ready), "R8", {31'b0, win_ready}, 32'h0);
                chk(!(nout_valid && txq.size() == 0), "R6", {31'b0, nout_valid}, 32'h0);
                if (nout_valid && nout_ready && txq.size() != 0) begin
                    e = {16'h0, txq.pop_front()};
                    chk(nout_data == e[15:0], cfg_nopack ? "R7" : "R6", {16'h0, nout_data}, e);
                    if (!cfg_wide)
                        chk(nout_data[15:8] == 8'h0, "R9", {16'h0, nout_data}, e);
                end
                if (win_valid && win_ready) begin
                    for (int k = 0; k < nbeats(); k++) begin
                        int lane;
                        logic [31:0] v;
                        lane = (cfg_msb && !cfg_nopack) ? (nbeats() - 1 - k) : k;
                        v = win_data >> (lane * lwidth());
                        txq.push_back(cfg_wide ? v[15:0] : {8'h0, v[7:0]});
                    end
                end
            end
        end
    end

    // random back-pressure on the two output streams
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rdy_en) begin
                wout_ready = ($urandom % 4) != 0;
                nout_ready = ($urandom % 3) != 0;
            end else begin
                wout_ready = 1'b0;
                nout_ready = 1'b0;
            end
        end
    end

    task automatic send_rx(input logic [15:0] d);
        bit hs;
        nin_data  = d;
        nin_valid = 1'b1;
        hs = 1'b0;
        while (!hs) begin
            @(negedge clk);
            hs = nin_ready;
            @(posedge clk);
            #1;
        end
        nin_valid = 1'b0;
    endtask

    task automatic send_tx(input logic [31:0] d);
        bit hs;
        win_data  = d;
        win_valid = 1'b1;
        hs = 1'b0;
        while (!hs) begin
            @(negedge clk);
            hs = win_ready;
            @(posedge clk);
            #1;
        end
        win_valid = 1'b0;
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while ((rxq.size() != 0 || txq.size() != 0) && guard < 2000) begin
            @(posedge clk);
            #1;
            guard++;
        end
        repeat (4) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic run_phase(input bit w, input bit np, input bit m);
        int beats;
        cfg_wide   = w;
        cfg_nopack = np;
        cfg_msb    = m;
        rx_note    = "R12";
        beats      = nbeats() * 4;
        fork
            for (int i = 0; i < beats; i++) send_rx(16'($urandom));
            for (int i = 0; i < 4; i++) send_tx($urandom);
        join
        drain();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!wout_valid, "R11", {31'b0, wout_valid}, 32'h0);
        chk(!nout_valid, "R11", {31'b0, nout_valid}, 32'h0);
        chk(nin_ready,   "R11", {31'b0, nin_ready},  32'h1);
        chk(win_ready,   "R11", {31'b0, win_ready},  32'h1);
        @(posedge clk);
        #1;
        rdy_en = 1'b1;

        for (int c = 0; c < 8; c++)
            run_phase(c[0], c[1], c[2]);
        run_phase(1'b0, 1'b0, 1'b0);

        // clear over a partial receive group and a pending transmit word
        rdy_en = 1'b0;
        @(posedge clk);
        #1;
        send_rx(16'h00a1);
        send_rx(16'h00b2);
        send_tx(32'hcafe_f00d);
        clr = 1'b1;
        @(posedge clk);
        #1;
        clr = 1'b0;
        @(negedge clk);
        chk(!wout_valid, "R10", {31'b0, wout_valid}, 32'h0);
        chk(!nout_valid, "R10", {31'b0, nout_valid}, 32'h0);
        chk(win_ready,   "R10", {31'b0, win_ready},  32'h1);
        @(posedge clk);
        #1;
        rdy_en  = 1'b1;
        rx_note = "R10";
        send_rx(16'h0011);
        send_rx(16'h0022);
        send_rx(16'h0033);
        send_rx(16'h0044);
        drain();
        chk(rxq.size() == 0 && txq.size() == 0, "R10", rxq.size(), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule